// File: doc/BRIEF.md
# Timer Frame Access Gate

This block sits between a register bus and the counter/timer registers of up to eight memory-mapped timer frames. It filters every access a frame receives. Each access names a frame, a register class, whether it came through the frame's unprivileged view, and whether it was made in the secure state. The block checks the access against that frame's 6-bit access-control field, its 10-bit unprivileged-view enable register and its non-secure enable bit. A permitted read returns the timer core's data. A refused read returns zero. A write reaches the core only when the permission rule for the class allows it. No access ever signals an error.

The same block serves the global control frame. There software programs the per-frame access-control fields and the non-secure enable vector, and reads an identification word that describes which frames exist and which of them have an unprivileged view. The timer arithmetic and the bus fabric stay outside. The block is purely a permission and read-out filter with a small amount of configuration storage.

Top module: `tfg_access_gate`

## Requirements
- R1: After reset every access-control field is 0, the non-secure enable vector is 0, and every frame's unprivileged-view enable register reads 0x303.
- R2: A control-frame write to a frame's access-control field (select code 0) stores only data bits [5:0]. The bit meanings are: bit0 physical count read, bit1 virtual count read, bit2 frequency read, bit3 virtual offset read, bit4 virtual timer access, bit5 physical timer access.
- R3: Physical count (class 0) and virtual count (class 1) are readable when their access bit is set. Through the unprivileged view they also need unprivileged-view enable bit 0 (physical count) or bit 1 (virtual count), respectively.
- R4: Frequency (class 2) is readable when access bit 2 is set. Through the unprivileged view it also needs at least one of unprivileged-view enable bits 0 and 1.
- R5: Virtual offset (class 3) is readable only from the privileged view, and only with access bit 3 set. Through the unprivileged view it always reads zero.
- R6: The physical timer (class 4) and the virtual timer (class 5) are readable and writable with access bit 5 or access bit 4, respectively. Through the unprivileged view they also need unprivileged-view enable bit 9 or bit 8, respectively. A permitted write raises `fr_core_we`; a refused write does not.
- R7: Writes to classes 0 to 3 never raise `fr_core_we`, whatever the permissions.
- R8: A refused read returns all zeros on `fr_rdata`. Refusals produce no error indication.
- R9: With security present, a non-secure access to a frame whose non-secure enable bit is clear is refused. This holds both in the frame and for that frame's access-control field in the control frame. The non-secure enable vector (select code 1) can be written and read only by secure accesses. It keeps one bit per present frame; bit i is frame i.
- R10: The identification word (select code 2) holds a 4-bit field per frame at bits [4i+3:4i]. The field has bit 0 set for a present frame and bit 2 set when that frame has an unprivileged view. Absent frames give 0.
- R11: An unprivileged-view access to a frame that has no unprivileged view is refused. So is any access to a frame index at or above the frame count.
- R12: The unprivileged-view enable register (class 6) is readable and writable from the privileged view only, and stores only the bits in mask 0x303. Unprivileged-view accesses to it read zero and are ignored. Class 7 always reads zero and ignores writes.
- R13: When the block is built without security support, the non-secure enable bits have no effect and non-secure accesses are judged by the other rules alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fr_req | input | 1 | Frame access valid this cycle |
| fr_wr | input | 1 | Frame access is a write |
| fr_frame | input | 3 | Frame index |
| fr_cls | input | 3 | Register class code (0 to 7) |
| fr_unpriv | input | 1 | Access made through the unprivileged view |
| fr_secure | input | 1 | Access made in the secure state |
| fr_wdata | input | DATA_W | Frame write data |
| fr_core_rdata | input | DATA_W | Register value supplied by the timer core |
| fr_rdata | output | DATA_W | Filtered read data |
| fr_core_we | output | 1 | Write permitted to reach the timer core |
| ctl_req | input | 1 | Control-frame access valid |
| ctl_wr | input | 1 | Control-frame access is a write |
| ctl_sel | input | 2 | Control register select (0 access field, 1 non-secure enables, 2 identification, 3 none) |
| ctl_frame | input | 3 | Frame whose access-control field is addressed |
| ctl_secure | input | 1 | Control access made in the secure state |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control read data |

## Verification
The hardest situation to reach is a refusal caused by the unprivileged-view enables while the privileged access bits already allow the access. The stimulus first grants the privileged bit through the control frame. It then narrows the frame's own enable register with a privileged write, and only then issues the unprivileged access, so the refusal can be pinned to the enable bit alone. The non-secure cases need a similar ordering. The access bits are set while the frame is closed to non-secure access, a non-secure attempt to open it is shown to have no effect, and a secure write then opens it. A second instance built without security support receives the same traffic, and its reads show that the enable vector is ignored there.

// File: rtl/tfg_pkg.sv
// Package: shared constants and encodings for the timer frame access gate.
// Assumes at most eight frames; bit positions here are visible to software.
package tfg_pkg;

    localparam int MAX_FRAMES  = 8;
    localparam int FRAME_IDX_W = $clog2(MAX_FRAMES);
    localparam int ACR_W       = 6;
    localparam int UEN_W       = 10;
    localparam int CTL_W       = 32;
    localparam int ID_NIB_W    = 4;

    localparam logic [UEN_W-1:0] UEN_MASK  = 10'h303;
    localparam logic [UEN_W-1:0] UEN_RESET = 10'h303;

    // Access-control field bit positions
    localparam int ACB_PCOUNT = 0;
    localparam int ACB_VCOUNT = 1;
    localparam int ACB_FREQ   = 2;
    localparam int ACB_VOFF   = 3;
    localparam int ACB_VTMR   = 4;
    localparam int ACB_PTMR   = 5;

    // Unprivileged-view enable bit positions
    localparam int UEB_PCOUNT = 0;
    localparam int UEB_VCOUNT = 1;
    localparam int UEB_VTMR   = 8;
    localparam int UEB_PTMR   = 9;

    typedef enum logic [2:0] {
        CLS_PCOUNT  = 3'd0,
        CLS_VCOUNT  = 3'd1,
        CLS_FREQ    = 3'd2,
        CLS_VOFFSET = 3'd3,
        CLS_PTIMER  = 3'd4,
        CLS_VTIMER  = 3'd5,
        CLS_UEN     = 3'd6,
        CLS_NONE    = 3'd7
    } reg_cls_e;

    typedef enum logic [1:0] {
        CSEL_ACR   = 2'd0,
        CSEL_NSEN  = 2'd1,
        CSEL_IDENT = 2'd2,
        CSEL_NONE  = 2'd3
    } ctl_sel_e;

endpackage

// File: rtl/tfg_cfg_store.sv
// Module: per-frame configuration storage (access-control fields,
// unprivileged-view enables, non-secure enable vector) with read muxes
// for the frame port and the control port. Assumes write strobes are
// already permission-qualified by the caller.
module tfg_cfg_store
    import tfg_pkg::*;
#(
    parameter int NUM_FRAMES = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acr_we,
    input  logic [FRAME_IDX_W-1:0]     acr_idx,
    input  logic [ACR_W-1:0]           acr_wdata,
    input  logic                       uen_we,
    input  logic [FRAME_IDX_W-1:0]     uen_idx,
    input  logic [UEN_W-1:0]           uen_wdata,
    input  logic                       ns_we,
    input  logic [NUM_FRAMES-1:0]      ns_wdata,
    input  logic [FRAME_IDX_W-1:0]     fr_idx,
    input  logic [FRAME_IDX_W-1:0]     ctl_idx,
    output logic [ACR_W-1:0]           fr_acr,
    output logic [UEN_W-1:0]           fr_uen,
    output logic                       fr_ns,
    output logic [ACR_W-1:0]           ctl_acr,
    output logic                       ctl_ns,
    output logic [NUM_FRAMES-1:0]      ns_all
);

    logic [NUM_FRAMES-1:0][ACR_W-1:0] acr_q;
    logic [NUM_FRAMES-1:0][UEN_W-1:0] uen_q;
    logic [NUM_FRAMES-1:0]            ns_q;

    genvar g;
    generate
        for (g = 0; g < NUM_FRAMES; g++) begin : g_frame
            // Holds one frame's access-control field
            always_ff @(posedge clk) begin
                if (!rst_n)
                    acr_q[g] <= '0;
                else if (acr_we && (int'(acr_idx) == g))
                    acr_q[g] <= acr_wdata;
            end

            // Holds one frame's unprivileged-view enables, masked bits only
            always_ff @(posedge clk) begin
                if (!rst_n)
                    uen_q[g] <= UEN_RESET;
                else if (uen_we && (int'(uen_idx) == g))
                    uen_q[g] <= uen_wdata & UEN_MASK;
            end

            AST_UEN_RESET_VAL: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> (uen_q[g] == UEN_RESET)); // R1
        end
    endgenerate

    // Holds the non-secure enable vector
    always_ff @(posedge clk) begin
        if (!rst_n)
            ns_q <= '0;
        else if (ns_we)
            ns_q <= ns_wdata;
    end

    // Selects the addressed frame's fields for both ports, zero when absent
    always_comb begin
        fr_acr  = '0;
        fr_uen  = '0;
        fr_ns   = 1'b0;
        ctl_acr = '0;
        ctl_ns  = 1'b0;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if (int'(fr_idx) == i) begin
                fr_acr = acr_q[i];
                fr_uen = uen_q[i];
                fr_ns  = ns_q[i];
            end
            if (int'(ctl_idx) == i) begin
                ctl_acr = acr_q[i];
                ctl_ns  = ns_q[i];
            end
        end
    end

    assign ns_all = ns_q;

    AST_ACR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acr_we |=> $stable(acr_q)); // R2

endmodule

// File: rtl/tfg_perm_decode.sv
// Module: combinational permission rule per register class. Combines the
// frame's access-control field with its unprivileged-view enables.
// Assumes frame presence and security have been checked elsewhere.
module tfg_perm_decode
    import tfg_pkg::*;
(
    input  logic [2:0]       cls,
    input  logic             unpriv,
    input  logic [ACR_W-1:0] acr,
    input  logic [UEN_W-1:0] uen,
    output logic             rd_ok,
    output logic             wr_ok,
    output logic             is_uen
);

    reg_cls_e cls_e;
    assign cls_e = reg_cls_e'(cls);

    // Evaluates the compound read/write rule of the addressed class
    always_comb begin
        rd_ok  = 1'b0;
        wr_ok  = 1'b0;
        is_uen = 1'b0;
        unique case (cls_e)
            CLS_PCOUNT:  rd_ok = acr[ACB_PCOUNT] && (!unpriv || uen[UEB_PCOUNT]);
            CLS_VCOUNT:  rd_ok = acr[ACB_VCOUNT] && (!unpriv || uen[UEB_VCOUNT]);
            CLS_FREQ:    rd_ok = acr[ACB_FREQ] &&
                                 (!unpriv || uen[UEB_PCOUNT] || uen[UEB_VCOUNT]);
            CLS_VOFFSET: rd_ok = acr[ACB_VOFF] && !unpriv;
            CLS_PTIMER: begin
                rd_ok = acr[ACB_PTMR] && (!unpriv || uen[UEB_PTMR]);
                wr_ok = rd_ok;
            end
            CLS_VTIMER: begin
                rd_ok = acr[ACB_VTMR] && (!unpriv || uen[UEB_VTMR]);
                wr_ok = rd_ok;
            end
            CLS_UEN: begin
                rd_ok  = !unpriv;
                wr_ok  = !unpriv;
                is_uen = 1'b1;
            end
            default: begin
                rd_ok = 1'b0;
                wr_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tfg_ident.sv
// Module: builds the identification word, one 4-bit field per frame slot.
// Assumes NUM_FRAMES <= MAX_FRAMES; absent slots read zero.
module tfg_ident
    import tfg_pkg::*;
#(
    parameter int                    NUM_FRAMES = 6,
    parameter logic [MAX_FRAMES-1:0] UVIEW_MASK = 8'h15
) (
    output logic [CTL_W-1:0] ident
);

    genvar g;
    generate
        for (g = 0; g < MAX_FRAMES; g++) begin : g_slot
            if (g < NUM_FRAMES) begin : g_present
                assign ident[g*ID_NIB_W +: ID_NIB_W] = {1'b0, UVIEW_MASK[g], 1'b0, 1'b1};
            end else begin : g_absent
                assign ident[g*ID_NIB_W +: ID_NIB_W] = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/tfg_access_gate.sv
// Module: top of the timer frame access gate. Filters frame register
// accesses by class permission, unprivileged view and security state,
// and serves the control frame (access fields, non-secure enables, ident).
// Assumes one access per port per cycle; outputs are combinational.
module tfg_access_gate
    import tfg_pkg::*;
#(
    parameter int                    DATA_W       = 64,
    parameter int                    NUM_FRAMES   = 6,
    parameter logic [MAX_FRAMES-1:0] UVIEW_MASK   = 8'h15,
    parameter bit                    HAS_SECURITY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fr_req,
    input  logic              fr_wr,
    input  logic [2:0]        fr_frame,
    input  logic [2:0]        fr_cls,
    input  logic              fr_unpriv,
    input  logic              fr_secure,
    input  logic [DATA_W-1:0] fr_wdata,
    input  logic [DATA_W-1:0] fr_core_rdata,
    output logic [DATA_W-1:0] fr_rdata,
    output logic              fr_core_we,
    input  logic              ctl_req,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_sel,
    input  logic [2:0]        ctl_frame,
    input  logic              ctl_secure,
    input  logic [31:0]       ctl_wdata,
    output logic [31:0]       ctl_rdata
);

    localparam logic [MAX_FRAMES-1:0] PRESENT = MAX_FRAMES'((1 << NUM_FRAMES) - 1);

    logic [ACR_W-1:0]      fr_acr, ctl_acr;
    logic [UEN_W-1:0]      fr_uen;
    logic                  fr_ns, ctl_ns;
    logic [NUM_FRAMES-1:0] ns_all;
    logic [CTL_W-1:0]      ident;
    logic                  rd_ok, wr_ok, is_uen;
    logic                  fr_gate, ctl_acr_ok, ctl_priv_sec;
    logic                  acr_we, uen_we, ns_we;
    ctl_sel_e              sel_e;

    assign sel_e = ctl_sel_e'(ctl_sel);

    tfg_cfg_store #(.NUM_FRAMES(NUM_FRAMES)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .acr_we   (acr_we),
        .acr_idx  (ctl_frame),
        .acr_wdata(ctl_wdata[ACR_W-1:0]),
        .uen_we   (uen_we),
        .uen_idx  (fr_frame),
        .uen_wdata(fr_wdata[UEN_W-1:0]),
        .ns_we    (ns_we),
        .ns_wdata (ctl_wdata[NUM_FRAMES-1:0]),
        .fr_idx   (fr_frame),
        .ctl_idx  (ctl_frame),
        .fr_acr   (fr_acr),
        .fr_uen   (fr_uen),
        .fr_ns    (fr_ns),
        .ctl_acr  (ctl_acr),
        .ctl_ns   (ctl_ns),
        .ns_all   (ns_all)
    );

    tfg_perm_decode u_dec (
        .cls   (fr_cls),
        .unpriv(fr_unpriv),
        .acr   (fr_acr),
        .uen   (fr_uen),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok),
        .is_uen(is_uen)
    );

    tfg_ident #(.NUM_FRAMES(NUM_FRAMES), .UVIEW_MASK(UVIEW_MASK)) u_id (
        .ident(ident)
    );

    // Frame-level admission: presence, view availability, security
    always_comb begin
        fr_gate = fr_req && PRESENT[fr_frame] &&
                  (!fr_unpriv || UVIEW_MASK[fr_frame]) &&
                  (!HAS_SECURITY || fr_secure || fr_ns);
    end

    // Read data and write strobes toward the core and the enable store
    always_comb begin
        fr_rdata   = '0;
        if (fr_gate && rd_ok)
            fr_rdata = is_uen ? DATA_W'(fr_uen) : fr_core_rdata;
        fr_core_we = fr_gate && fr_wr && wr_ok && !is_uen;
        uen_we     = fr_gate && fr_wr && wr_ok && is_uen;
    end

    // Control-frame permission and write strobes
    always_comb begin
        ctl_priv_sec = !HAS_SECURITY || ctl_secure;
        ctl_acr_ok   = PRESENT[ctl_frame] && (ctl_priv_sec || ctl_ns);
        acr_we = ctl_req && ctl_wr && (sel_e == CSEL_ACR) && ctl_acr_ok;
        ns_we  = ctl_req && ctl_wr && (sel_e == CSEL_NSEN) && ctl_priv_sec;
    end

    // Control-frame read multiplexer, zero when refused or idle
    always_comb begin
        ctl_rdata = '0;
        if (ctl_req) begin
            unique case (sel_e)
                CSEL_ACR:   if (ctl_acr_ok)   ctl_rdata = CTL_W'(ctl_acr);
                CSEL_NSEN:  if (ctl_priv_sec) ctl_rdata = CTL_W'(ns_all);
                CSEL_IDENT: ctl_rdata = ident;
                default:    ctl_rdata = '0;
            endcase
        end
    end

    logic unused_ok;
    assign unused_ok = ^{fr_wdata, ctl_wdata};

    AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fr_core_we |-> (fr_cls == CLS_PTIMER || fr_cls == CLS_VTIMER)); // R7

    AST_VOFF_UVIEW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_req && fr_unpriv && fr_cls == CLS_VOFFSET) |-> (fr_rdata == '0)); // R5

    AST_NS_FRAME_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_SECURITY && fr_req && !fr_secure && !fr_ns) |->
            (fr_rdata == '0 && !fr_core_we)); // R9

    AST_NSEN_SECURE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_SECURITY && ctl_req && ctl_wr && !ctl_secure) |=> $stable(ns_all)); // R9

endmodule

// File: tb/tfg_access_gate_bench.sv
`timescale 1ns/100ps
module tfg_access_gate_bench;

    localparam int DW = 64;
    localparam logic [DW-1:0] CORE = 64'hA5A5_0000_1234_5678;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fr_req = 0, fr_wr = 0, fr_unpriv = 0, fr_secure = 0;
    logic [2:0] fr_frame = 0, fr_cls = 0;
    logic [DW-1:0] fr_wdata = 0;
    logic [DW-1:0] fr_core_rdata = CORE;
    logic [DW-1:0] fr_rdata, ns_fr_rdata;
    logic fr_core_we, ns_fr_core_we;
    logic ctl_req = 0, ctl_wr = 0, ctl_secure = 0;
    logic [1:0] ctl_sel = 0;
    logic [2:0] ctl_frame = 0;
    logic [31:0] ctl_wdata = 0;
    logic [31:0] ctl_rdata, ns_ctl_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] s_rd, s_rd_ns;
    logic s_we;
    logic [31:0] s_crd;

    always #2.5 clk = ~clk;

    tfg_access_gate u_tfg_access_gate (
        .clk(clk), .rst_n(rst_n),
        .fr_req(fr_req), .fr_wr(fr_wr), .fr_frame(fr_frame), .fr_cls(fr_cls),
        .fr_unpriv(fr_unpriv), .fr_secure(fr_secure), .fr_wdata(fr_wdata),
        .fr_core_rdata(fr_core_rdata), .fr_rdata(fr_rdata), .fr_core_we(fr_core_we),
        .ctl_req(ctl_req), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_frame(ctl_frame),
        .ctl_secure(ctl_secure), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
    );

    tfg_access_gate #(.HAS_SECURITY(1'b0)) u_tfg_access_gate_nosec (
        .clk(clk), .rst_n(rst_n),
        .fr_req(fr_req), .fr_wr(fr_wr), .fr_frame(fr_frame), .fr_cls(fr_cls),
        .fr_unpriv(fr_unpriv), .fr_secure(fr_secure), .fr_wdata(fr_wdata),
        .fr_core_rdata(fr_core_rdata), .fr_rdata(ns_fr_rdata), .fr_core_we(ns_fr_core_we),
        .ctl_req(ctl_req), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_frame(ctl_frame),
        .ctl_secure(ctl_secure), .ctl_wdata(ctl_wdata), .ctl_rdata(ns_ctl_rdata)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Frame access: drive after a falling edge, sample, release at next falling edge
    task automatic fr_acc(input logic wr, input int frame, input int cls,
                          input logic up, input logic sec, input logic [DW-1:0] wd);
        fr_req = 1; fr_wr = wr; fr_frame = 3'(frame); fr_cls = 3'(cls);
        fr_unpriv = up; fr_secure = sec; fr_wdata = wd;
        #1;
        s_rd = fr_rdata; s_rd_ns = ns_fr_rdata; s_we = fr_core_we;
        @(negedge clk);
        fr_req = 0; fr_wr = 0;
    endtask

    task automatic ctl_acc(input logic wr, input int sel, input int frame,
                           input logic sec, input logic [31:0] wd);
        ctl_req = 1; ctl_wr = wr; ctl_sel = 2'(sel); ctl_frame = 3'(frame);
        ctl_secure = sec; ctl_wdata = wd;
        #1;
        s_crd = ctl_rdata;
        @(negedge clk);
        ctl_req = 0; ctl_wr = 0;
    endtask

    task automatic set_acr(input int frame, input logic [31:0] v);
        ctl_acc(1, 0, frame, 1, v);
    endtask

    task automatic set_uen(input int frame, input logic [DW-1:0] v);
        fr_acc(1, frame, 6, 0, 1, v);
    endtask

    task automatic t_reset;
        ctl_acc(0, 1, 0, 1, 0);  check("R1 nsen reset", DW'(s_crd), 0);
        ctl_acc(0, 0, 0, 1, 0);  check("R1 acr reset", DW'(s_crd), 0);
        fr_acc(0, 0, 6, 0, 1, 0); check("R1 uen f0 reset", s_rd, 64'h303);
        fr_acc(0, 5, 6, 0, 1, 0); check("R1 uen f5 reset", s_rd, 64'h303);
        fr_acc(0, 0, 0, 0, 1, 0); check("R8 pcount denied reads zero", s_rd, 0);
    endtask

    task automatic t_acr_mask;
        set_acr(1, 32'hFFFF_FFC5);
        ctl_acc(0, 0, 1, 1, 0); check("R2 acr low six bits", DW'(s_crd), 64'h05);
    endtask

    task automatic t_counts;
        set_acr(0, 32'h03);
        fr_acc(0, 0, 0, 0, 1, 0); check("R3 priv pcount", s_rd, CORE);
        fr_acc(0, 0, 1, 0, 1, 0); check("R3 priv vcount", s_rd, CORE);
        set_acr(0, 32'h02);
        fr_acc(0, 0, 0, 0, 1, 0); check("R3 pcount bit clear", s_rd, 0);
        fr_acc(0, 0, 1, 1, 1, 0); check("R3 uview vcount enabled", s_rd, CORE);
        set_uen(0, 64'h301);
        fr_acc(0, 0, 1, 1, 1, 0); check("R3 uview vcount disabled", s_rd, 0);
        fr_acc(0, 0, 1, 0, 1, 0); check("R3 priv vcount unaffected", s_rd, CORE);
    endtask

    task automatic t_freq;
        set_acr(0, 32'h04);
        set_uen(0, 64'h300);
        fr_acc(0, 0, 2, 0, 1, 0); check("R4 priv freq", s_rd, CORE);
        fr_acc(0, 0, 2, 1, 1, 0); check("R4 uview freq no count enable", s_rd, 0);
        set_uen(0, 64'h301);
        fr_acc(0, 0, 2, 1, 1, 0); check("R4 uview freq pcount enable", s_rd, CORE);
        set_uen(0, 64'h302);
        fr_acc(0, 0, 2, 1, 1, 0); check("R4 uview freq vcount enable", s_rd, CORE);
        set_acr(0, 32'h3B);
        fr_acc(0, 0, 2, 0, 1, 0); check("R4 freq bit clear", s_rd, 0);
    endtask

    task automatic t_voff;
        set_acr(0, 32'h08);
        set_uen(0, 64'h303);
        fr_acc(0, 0, 3, 0, 1, 0); check("R5 priv voffset", s_rd, CORE);
        fr_acc(0, 0, 3, 1, 1, 0); check("R5 uview voffset", s_rd, 0);
        set_acr(0, 32'h37);
        fr_acc(0, 0, 3, 0, 1, 0); check("R5 voffset bit clear", s_rd, 0);
    endtask

    task automatic t_timers;
        set_acr(2, 32'h20);
        fr_acc(1, 2, 4, 0, 1, 64'h55); check("R6 priv ptimer write", DW'(s_we), 1);
        fr_acc(0, 2, 4, 0, 1, 0);      check("R6 priv ptimer read", s_rd, CORE);
        fr_acc(1, 2, 5, 0, 1, 64'h55); check("R6 vtimer write denied", DW'(s_we), 0);
        fr_acc(0, 2, 5, 0, 1, 0);      check("R8 vtimer read denied", s_rd, 0);
        set_uen(2, 64'h103);
        fr_acc(1, 2, 4, 1, 1, 64'h55); check("R6 uview ptimer write disabled", DW'(s_we), 0);
        fr_acc(0, 2, 4, 1, 1, 0);      check("R6 uview ptimer read disabled", s_rd, 0);
        set_uen(2, 64'h200);
        fr_acc(1, 2, 4, 1, 1, 64'h55); check("R6 uview ptimer write enabled", DW'(s_we), 1);
        set_acr(2, 32'h10);
        fr_acc(1, 2, 5, 0, 1, 64'h55); check("R6 priv vtimer write", DW'(s_we), 1);
    endtask

    task automatic t_readonly;
        set_acr(0, 32'h3F);
        for (int c = 0; c < 4; c++) begin
            fr_acc(1, 0, c, 0, 1, 64'hFFFF); check("R7 read-only class write", DW'(s_we), 0);
        end
    endtask

    task automatic t_uen_reg;
        set_uen(4, 64'hFFFF);
        fr_acc(0, 4, 6, 0, 1, 0);  check("R12 uen masked", s_rd, 64'h303);
        fr_acc(1, 4, 6, 1, 1, 0);
        fr_acc(0, 4, 6, 0, 1, 0);  check("R12 uview uen write ignored", s_rd, 64'h303);
        fr_acc(0, 4, 6, 1, 1, 0);  check("R12 uview uen reads zero", s_rd, 0);
        fr_acc(0, 4, 7, 0, 1, 0);  check("R12 class 7 reads zero", s_rd, 0);
    endtask

    task automatic t_ns;
        set_acr(3, 32'h3F);
        fr_acc(0, 3, 0, 0, 0, 0);  check("R9 nonsecure frame blocked", s_rd, 0);
        check("R13 no-security instance ignores enables", s_rd_ns, CORE);
        fr_acc(1, 3, 4, 0, 0, 1);  check("R9 nonsecure write blocked", DW'(s_we), 0);
        ctl_acc(0, 0, 3, 0, 0);    check("R9 nonsecure acr read blocked", DW'(s_crd), 0);
        ctl_acc(1, 1, 0, 0, 32'hFF);
        ctl_acc(0, 1, 0, 1, 0);    check("R9 nonsecure nsen write ignored", DW'(s_crd), 0);
        ctl_acc(1, 1, 0, 1, 32'hFF);
        ctl_acc(0, 1, 0, 1, 0);    check("R9 nsen present frames only", DW'(s_crd), 64'h3F);
        ctl_acc(0, 1, 0, 0, 0);    check("R9 nonsecure nsen read zero", DW'(s_crd), 0);
        fr_acc(0, 3, 0, 0, 0, 0);  check("R9 nonsecure frame opened", s_rd, CORE);
        ctl_acc(0, 0, 3, 0, 0);    check("R9 nonsecure acr read opened", DW'(s_crd), 64'h3F);
    endtask

    task automatic t_ident;
        ctl_acc(0, 2, 0, 1, 0);    check("R10 ident word", DW'(s_crd), 64'h0015_1515);
        ctl_acc(0, 2, 0, 0, 0);    check("R10 ident nonsecure", DW'(s_crd), 64'h0015_1515);
    endtask

    task automatic t_absent;
        set_acr(1, 32'h3F);
        fr_acc(0, 1, 0, 1, 1, 0);  check("R11 uview on frame without view", s_rd, 0);
        fr_acc(0, 1, 0, 0, 1, 0);  check("R11 priv on same frame", s_rd, CORE);
        fr_acc(0, 6, 0, 0, 1, 0);  check("R11 absent frame read", s_rd, 0);
        fr_acc(1, 7, 4, 0, 1, 1);  check("R11 absent frame write", DW'(s_we), 0);
        set_acr(7, 32'h3F);
        ctl_acc(0, 0, 7, 1, 0);    check("R11 absent frame acr", DW'(s_crd), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_acr_mask();
        t_counts();
        t_freq();
        t_voff();
        t_timers();
        t_readonly();
        t_uen_reg();
        t_ns();
        t_ident();
        t_absent();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule